// File: doc/BRIEF.md
# Byte-Addressed Seconds Counter Real-Time Clock

This block keeps wall-clock time as a free-running 32-bit count of seconds and raises an alarm interrupt when that count reaches a programmed 32-bit value. A one-cycle pulse on `secTick` marks each elapsed second. All state is reached through a byte-wide register bus, which has an address, write data, a write strobe and combinational read data.

Software sets the time by staging the three upper bytes and then writing the least significant byte. That last write loads all four bytes into the counter at once. Reads of the live byte window return the running count. Because the four bytes are read one at a time, software can see a carry between reads by reading the low byte a second time and comparing. The alarm fires once: when it fires, the hardware clears the alarm enable. The pending flag stays set and drives the interrupt until software clears it with a write-1.

Register offsets: 0x0 counter control, 0x1 alarm control, 0x2–0x5 time staging bytes 0..3, 0x6–0x9 live count bytes 0..3, 0xA–0xD alarm value bytes 0..3, 0xE alarm status/clear. In every multi-byte group, byte 0 is the least significant.

Top module: `byte_rtc`

## Requirements
- R1: After reset the counter, the staged bytes, the alarm value, both enable bits and the pending flag are all zero, so every register reads 0x00 and `alarmIrq` is low.
- R2: Bit 7 of offset 0x0 is the counter enable and bit 7 of offset 0x1 is the alarm enable. Both read back as written, and all other bits of these registers read 0.
- R3: Writes to offsets 0x3, 0x4 and 0x5 stage time bytes 1, 2 and 3. The staged bytes read back at those offsets, and writing them leaves the counter unchanged.
- R4: A write to offset 0x2 loads the counter, in the next cycle, with the written byte as bits 7:0 and staged bytes 1..3 as bits 31:8. A load takes priority over a tick in the same cycle.
- R5: While the counter enable is 1, each tick adds one to the counter, and 0xFFFFFFFF wraps to 0. While the enable is 0 the counter holds its value.
- R6: Offsets 0x6..0x9 return bytes 0..3 of the live counter, little-endian.
- R7: Offsets 0xA..0xD hold the alarm value bytes 0..3 and read back exactly what was written.
- R8: An alarm event occurs on a tick when the alarm enable is 1, the counter enable is 1, no load is under way and the counter equals the alarm value. The event sets the pending flag in the next cycle. With either enable at 0, no event occurs.
- R9: An alarm event clears the alarm enable bit, so the alarm does not fire again until software sets the bit again.
- R10: Bit 0 of offset 0xE reads the pending flag. Writing a 1 to that bit clears the flag and writing a 0 has no effect. If a clear and an alarm event fall in the same cycle, the flag stays set.
- R11: The pending flag is sticky until cleared, and `alarmIrq` is a level equal to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| busAddr | input | 4 | Register offset |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, one write per cycle |
| busRdata | output | 8 | Read data for `busAddr`, combinational |
| alarmIrq | output | 1 | Level alarm interrupt |

## Verification
The assertions assume that the bus inputs and `secTick` carry defined values in every cycle after reset, and that a write is a single-cycle strobe whose address and data are valid in the cycle the strobe is high. The properties put no limit on how often ticks come. The bench changes inputs only on the falling clock edge and raises each write and each tick for exactly one cycle. The one place it drives a write and a tick together is where the requirements define a priority: a load against a tick, and a clear against an alarm event.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int TIME_BYTES = 4;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int CNT_W      = DATA_W * TIME_BYTES;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_ACTL  = 1;
  localparam int OFS_STAGE = 2;
  localparam int OFS_LIVE  = OFS_STAGE + TIME_BYTES;
  localparam int OFS_ALARM = OFS_LIVE + TIME_BYTES;
  localparam int OFS_STAT  = OFS_ALARM + TIME_BYTES;

  localparam int EN_BIT  = 7;
  localparam int CLR_BIT = 0;

  typedef struct packed {
    logic                  commit;
    logic [TIME_BYTES-1:0] stageWe;
    logic [TIME_BYTES-1:0] alarmWe;
  } rtc_strb_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              almHit,
  output rtc_strb_t         strb,
  output logic              cntEn,
  output logic              almEn,
  output logic              pending,
  output logic              ctrlSel,
  output logic [DATA_W-1:0] ctrlRdata
);
  logic ctrlWr, actlWr, statWr;

  assign ctrlWr = busWe && (busAddr == ADDR_W'(OFS_CTRL));
  assign actlWr = busWe && (busAddr == ADDR_W'(OFS_ACTL));
  assign statWr = busWe && (busAddr == ADDR_W'(OFS_STAT));

  for (genvar i = 0; i < TIME_BYTES; i++) begin : g_strb
    assign strb.stageWe[i] = busWe && (busAddr == ADDR_W'(OFS_STAGE + i));
    assign strb.alarmWe[i] = busWe && (busAddr == ADDR_W'(OFS_ALARM + i));
  end
  assign strb.commit = strb.stageWe[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn   <= 1'b0;
      almEn   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (ctrlWr) cntEn <= busWdata[EN_BIT];
      if (actlWr)      almEn <= busWdata[EN_BIT];
      else if (almHit) almEn <= 1'b0;
      if (almHit)                           pending <= 1'b1;
      else if (statWr && busWdata[CLR_BIT]) pending <= 1'b0;
    end
  end

  always_comb begin
    ctrlSel   = 1'b1;
    ctrlRdata = '0;
    if (busAddr == ADDR_W'(OFS_CTRL))      ctrlRdata[EN_BIT]  = cntEn;
    else if (busAddr == ADDR_W'(OFS_ACTL)) ctrlRdata[EN_BIT]  = almEn;
    else if (busAddr == ADDR_W'(OFS_STAT)) ctrlRdata[CLR_BIT] = pending;
    else                                   ctrlSel = 1'b0;
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    almHit && !actlWr |=> !almEn); // R9
  AST_HIT_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    almHit |=> pending); // R8
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(almEn) && $past(cntEn)); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    pending && !(statWr && busWdata[CLR_BIT]) |=> pending); // R11
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    statWr && busWdata[CLR_BIT] && !almHit |=> !pending); // R10
endmodule

// File: rtl/rtc_dp.sv
module rtc_dp
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              cntEn,
  input  logic              almEn,
  input  rtc_strb_t         strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              almHit,
  output logic [DATA_W-1:0] dpRdata
);
  logic [DATA_W-1:0] stageByte [TIME_BYTES];
  logic [DATA_W-1:0] alarmByte [TIME_BYTES];
  logic [CNT_W-1:0]  cnt, loadVal, alarmVal;

  for (genvar i = 0; i < TIME_BYTES; i++) begin : g_bytes
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageByte[i] <= '0;
        alarmByte[i] <= '0;
      end else begin
        if (strb.stageWe[i]) stageByte[i] <= busWdata;
        if (strb.alarmWe[i]) alarmByte[i] <= busWdata;
      end
    end
    assign alarmVal[DATA_W*i +: DATA_W] = alarmByte[i];
    if (i == 0) begin : g_low
      assign loadVal[DATA_W-1:0] = busWdata;
    end else begin : g_high
      assign loadVal[DATA_W*i +: DATA_W] = stageByte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 cnt <= '0;
    else if (strb.commit)      cnt <= loadVal;
    else if (cntEn && secTick) cnt <= cnt + CNT_W'(1);
  end

  assign almHit = secTick && cntEn && almEn && !strb.commit && (cnt == alarmVal);

  always_comb begin
    dpRdata = '0;
    for (int i = 0; i < TIME_BYTES; i++) begin
      if (busAddr == ADDR_W'(OFS_STAGE + i)) dpRdata = stageByte[i];
      if (busAddr == ADDR_W'(OFS_LIVE + i))  dpRdata = cnt[DATA_W*i +: DATA_W];
      if (busAddr == ADDR_W'(OFS_ALARM + i)) dpRdata = alarmByte[i];
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn && !strb.commit |=> $stable(cnt)); // R5
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    cntEn && secTick && !strb.commit |=> cnt == $past(cnt) + CNT_W'(1)); // R5
  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> cnt[DATA_W-1:0] == $past(busWdata)); // R4
endmodule

// File: rtl/byte_rtc.sv
module byte_rtc
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [3:0] busAddr,
  input  logic [7:0] busWdata,
  input  logic       busWe,
  output logic [7:0] busRdata,
  output logic       alarmIrq
);
  rtc_strb_t         strb;
  logic              cntEn, almEn, pending, almHit, ctrlSel;
  logic [DATA_W-1:0] ctrlRdata, dpRdata;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .almHit(almHit), .strb(strb), .cntEn(cntEn), .almEn(almEn), .pending(pending),
    .ctrlSel(ctrlSel), .ctrlRdata(ctrlRdata)
  );

  rtc_dp u_dp (
    .clk(clk), .rstN(rstN), .secTick(secTick), .cntEn(cntEn), .almEn(almEn),
    .strb(strb), .busAddr(busAddr), .busWdata(busWdata), .almHit(almHit),
    .dpRdata(dpRdata)
  );

  assign busRdata = ctrlSel ? ctrlRdata : dpRdata;
  assign alarmIrq = pending;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmIrq) |-> $past(almHit)); // R11
endmodule

// File: tb/byte_rtc_tb.sv
module byte_rtc_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWe = 1'b0;
  logic [7:0] busRdata;
  logic       alarmIrq;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_rtc u_dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRdata(busRdata), .alarmIrq(alarmIrq)
  );

  // {addr, write data, expected readback}
  localparam logic [19:0] VEC [12] = '{
    {4'h3, 8'h11, 8'h11}, {4'h4, 8'h22, 8'h22}, {4'h5, 8'h33, 8'h33}, // R3
    {4'hA, 8'hA5, 8'hA5}, {4'hB, 8'h5A, 8'h5A},                       // R7
    {4'hC, 8'hC3, 8'hC3}, {4'hD, 8'h3C, 8'h3C},                       // R7
    {4'h0, 8'hFF, 8'h80}, {4'h0, 8'h7F, 8'h00},                       // R2
    {4'h1, 8'h7F, 8'h00}, {4'h1, 8'h80, 8'h80}, {4'h1, 8'h00, 8'h00}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] a, input logic [7:0] d, input logic we, input logic tk);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = we; secTick = tk;
    @(negedge clk);
    busWe = 1'b0; secTick = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(a, d, 1'b1, 1'b0);
  endtask

  task automatic tick();
    cyc(4'h0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic rdLive(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(4'(6 + i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic loadCnt(input logic [31:0] v);
    wr(4'h5, v[31:24]); wr(4'h4, v[23:16]); wr(4'h3, v[15:8]); wr(4'h2, v[7:0]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), b);
      chk("R1 reset register", {24'd0, b}, 32'd0);
    end
    chk("R1 irq after reset", {31'd0, alarmIrq}, 32'd0);

    // table walk: write then read back
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], b);
      chk("R2/R3/R7 readback", {24'd0, b}, {24'd0, VEC[i][7:0]});
    end

    // R3 staging leaves counter at zero
    rdLive(v);
    chk("R3 counter untouched by staging", v, 32'd0);

    // R4 commit on low-byte write, R6 little-endian live view
    wr(4'h2, 8'h44);
    rdLive(v);
    chk("R4 R6 commit value", v, 32'h33221144);

    // R5 hold while disabled, step while enabled
    tick();
    rdLive(v);
    chk("R5 hold when disabled", v, 32'h33221144);
    wr(4'h0, 8'h80);
    tick();
    rdLive(v);
    chk("R5 step on tick", v, 32'h33221145);

    // R5 wrap
    loadCnt(32'hFFFFFFFF);
    tick();
    rdLive(v);
    chk("R5 wrap to zero", v, 32'd0);

    // R4 load beats tick
    wr(4'h5, 8'h01); wr(4'h4, 8'h02); wr(4'h3, 8'h03);
    cyc(4'h2, 8'h04, 1'b1, 1'b1);
    rdLive(v);
    chk("R4 load priority over tick", v, 32'h01020304);

    // R8 R9 alarm fires once
    wr(4'hA, 8'h10); wr(4'hB, 8'h00); wr(4'hC, 8'h00); wr(4'hD, 8'h00);
    loadCnt(32'h10);
    wr(4'h1, 8'h80);
    chk("R8 no irq before match", {31'd0, alarmIrq}, 32'd0);
    tick();
    chk("R8 irq after match", {31'd0, alarmIrq}, 32'd1);
    rd(4'h1, b);
    chk("R9 alarm enable self-cleared", {24'd0, b}, 32'd0);
    rd(4'hE, b);
    chk("R10 status bit reads pending", {24'd0, b}, 32'd1);

    // R11 sticky
    tick(); tick();
    chk("R11 irq stays high", {31'd0, alarmIrq}, 32'd1);

    // R10 clear
    wr(4'hE, 8'hFE);
    chk("R10 write 0 no effect", {31'd0, alarmIrq}, 32'd1);
    wr(4'hE, 8'h01);
    chk("R10 write 1 clears", {31'd0, alarmIrq}, 32'd0);

    // R8 counter disabled: no event
    wr(4'h0, 8'h00);
    loadCnt(32'h10);
    wr(4'h1, 8'h80);
    tick();
    chk("R8 no event with counter off", {31'd0, alarmIrq}, 32'd0);

    // R8 alarm disabled: no event
    wr(4'h1, 8'h00);
    wr(4'h0, 8'h80);
    tick();
    chk("R8 no event with alarm off", {31'd0, alarmIrq}, 32'd0);
    rdLive(v);
    chk("R5 counter advanced past match", v, 32'h11);

    // R10 clear and event together
    loadCnt(32'h10);
    wr(4'h1, 8'h80);
    cyc(4'hE, 8'h01, 1'b1, 1'b1);
    chk("R10 event wins over clear", {31'd0, alarmIrq}, 32'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule